// File: doc/BRIEF.md
# Windowed Flux-Transition Byte Assembler

This block is the read-side data separator of a floppy-style disk controller. Each clock cycle it may receive a single-cycle pulse marking a magnetic flux transition. It decides, for each bit cell, whether a 1 or a 0 arrived, and shifts that bit into an 8-bit assembly register. The bit-cell length in clock cycles comes from the controller's mode setting and is sampled live.

Timing is tracked by a cycles-since-last-shift counter. A transition is accepted only once the counter has passed half a cell, so early noise is rejected. When a transition is accepted, a 1 is shifted in and the counter restarts from zero, which re-centres the window on the real edge. If a cell and a half passes with no transition, a 0 is shifted in and the counter slides back by exactly one cell. Byte framing is self-clocking: the recorded byte is complete once a 1 reaches the top bit. The finished byte then moves to a data register that the host polls. A read strobe empties that register.

Top module: `flux_byte_asm`

## Requirements
- R1: After reset, `data_out` is 0x00 and the timer and assembly register hold zero.
- R2: The margin is `cell_len >> 1`. A flux pulse that arrives while the cycles-since-shift count is below the margin has no effect on the bits assembled.
- R3: A flux pulse that arrives while the count is at or above the margin shifts a 1 into the assembly register, and the count restarts at 0.
- R4: With no accepted pulse, the cycle in which the count would reach `cell_len + margin` shifts a 0 instead, and the count becomes the margin (reduced by one cell length). An accepted pulse in that same cycle takes priority. As a consequence, pulses spaced n cells apart (within the window) yield n-1 zeros and then a 1.
- R5: Bits enter at bit 0 and move toward bit 7. The cycle in which bit 7 becomes 1 copies the 8-bit value to `data_out` on the following edge and clears the assembly register.
- R6: A `data_rd` strobe while `data_out[7]` is 1 clears `data_out` to 0x00 at the next edge. A byte that completes in the same cycle wins over the clear.
- R7: While `read_en` is 0, the count and the assembly register are held at zero, flux pulses are ignored, and `data_out` keeps its value.
- R8: A byte that completes before the previous one was read overwrites it.
- R9: Any `cell_len` of 2 or more works, odd lengths included (margin rounds down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| read_en | input | 1 | Read mode enable; low clears the timer and assembly register |
| flux_pulse | input | 1 | Single-cycle flux transition pulse |
| cell_len | input | CELL_W | Bit-cell length in clock cycles (at least 2) |
| data_rd | input | 1 | Host read strobe of the data register |
| data_out | output | 8 | Data register; bit 7 set means a byte is waiting |

## Verification
The bench sends byte streams whose pulse spacing encodes the zeros between ones. Each pulse is jittered early and late inside the window, so a design that re-centred the window on a 0, or that slid it on a 1, would drift and insert or drop bits. A glitch pulse shortly after an accepted 1 would show up as an extra 1 in a design that checked the margin wrongly. Partial bytes left behind when read mode drops would corrupt the next byte in a design that did not clear the assembly register. Two bytes sent back to back without a read must leave the later one in the register. Both an odd and a long cell length are run, so that a wrong margin rounding would break framing.

// File: rtl/flux_asm_pkg.sv
package flux_asm_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        EVT_NONE = 2'd0,
        EVT_ZERO = 2'd1,
        EVT_ONE  = 2'd2
    } cell_evt_t;

    typedef struct packed {
        byte_t sr;
    } framer_st_t;

    typedef struct packed {
        byte_t data;
    } holder_st_t;

endpackage

// File: rtl/flux_cell_timer.sv
module flux_cell_timer
    import flux_asm_pkg::*;
#(
    parameter int CELL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              read_en,
    input  logic              flux_pulse,
    input  logic [CELL_W-1:0] cell_len,
    output cell_evt_t         evt
);

    localparam int CNT_W = CELL_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_st_t;

    timer_st_t st_q, st_d;

    logic [CNT_W-1:0] margin;
    logic [CNT_W-1:0] len_ext;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;
    cell_evt_t        evt_d;

    always_comb begin
        len_ext = {1'b0, cell_len};
        margin  = len_ext >> 1;
        limit   = len_ext + margin;
        cnt_inc = st_q.cnt + 1'b1;
        st_d    = st_q;
        evt_d   = EVT_NONE;
        if (!read_en) begin
            st_d.cnt = '0;
        end else if (flux_pulse && (st_q.cnt >= margin)) begin
            evt_d    = EVT_ONE;
            st_d.cnt = '0;
        end else if (cnt_inc >= limit) begin
            evt_d    = EVT_ZERO;
            st_d.cnt = cnt_inc - len_ext;
        end else begin
            st_d.cnt = cnt_inc;
        end
    end

    assign evt = evt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: an early pulse neither restarts nor disturbs the count
    p_early_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (read_en && flux_pulse && (st_q.cnt < margin) && (cnt_inc < limit))
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R3: an accepted pulse restarts the count
    p_one_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EVT_ONE) |=> (st_q.cnt == '0));

    // R4: a zero leaves the count at the margin of a stable cell length
    p_zero_slides_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EVT_ZERO) ##1 $stable(cell_len) |-> (st_q.cnt == margin));

    // R7: idle read mode keeps the count cleared
    p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !read_en |=> (st_q.cnt == '0));

endmodule

// File: rtl/flux_shift_framer.sv
module flux_shift_framer
    import flux_asm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      read_en,
    input  cell_evt_t evt,
    output logic      frame_done,
    output byte_t     frame_byte
);

    framer_st_t st_q, st_d;
    byte_t      shifted;

    always_comb begin
        st_d       = st_q;
        frame_done = 1'b0;
        shifted    = {st_q.sr[BYTE_W-2:0], (evt == EVT_ONE)};
        frame_byte = shifted;
        if (!read_en) begin
            st_d.sr = '0;
        end else if (evt != EVT_NONE) begin
            if (shifted[BYTE_W-1]) begin
                frame_done = 1'b1;
                st_d.sr    = '0;
            end else begin
                st_d.sr = shifted;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: the assembly register is empty after a byte is framed
    p_clear_on_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (st_q.sr == '0));

    // R5: bit 7 of the assembly register never rests at 1
    p_top_never_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> !st_q.sr[BYTE_W-1]);

    // R7: idle read mode keeps the assembly register empty
    p_idle_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !read_en |=> (st_q.sr == '0));

endmodule

// File: rtl/flux_data_holder.sv
module flux_data_holder
    import flux_asm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t load_byte,
    input  logic  rd,
    output byte_t data
);

    holder_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load)                        st_d.data = load_byte;
        else if (rd && st_q.data[BYTE_W-1]) st_d.data = '0;
    end

    assign data = st_q.data;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a read of a full register empties it when no byte arrives
    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && data[BYTE_W-1] && !load) |=> (data == '0));

    // R8: a loaded byte is always visible, whatever was there before
    p_load_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (data == $past(load_byte)));

    // R7: with no load and no read the register holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !rd) |=> $stable(data));

endmodule

// File: rtl/flux_byte_asm.sv
module flux_byte_asm
    import flux_asm_pkg::*;
#(
    parameter int CELL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              read_en,
    input  logic              flux_pulse,
    input  logic [CELL_W-1:0] cell_len,
    input  logic              data_rd,
    output logic [7:0]        data_out
);

    cell_evt_t evt;
    logic      frame_done;
    byte_t     frame_byte;
    byte_t     held;

    flux_cell_timer #(.CELL_W(CELL_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .read_en    (read_en),
        .flux_pulse (flux_pulse),
        .cell_len   (cell_len),
        .evt        (evt)
    );

    flux_shift_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .read_en    (read_en),
        .evt        (evt),
        .frame_done (frame_done),
        .frame_byte (frame_byte)
    );

    flux_data_holder u_holder (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_done),
        .load_byte (frame_byte),
        .rd        (data_rd),
        .data      (held)
    );

    assign data_out = held;

    // R5: every framed byte reaches the port with bit 7 set
    p_framed_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> data_out[7]);

    // R7: no events are produced while read mode is off
    p_no_evt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !read_en |-> (evt == EVT_NONE));

endmodule

// File: tb/flux_byte_asm_bench.sv
module flux_byte_asm_bench;

    localparam int CELL_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              read_en = 1'b0;
    logic              flux_pulse = 1'b0;
    logic [CELL_W-1:0] cell_len = 6'd8;
    logic              mon_rd = 1'b0;
    logic              man_rd = 1'b0;
    logic              mon_on = 1'b0;
    logic [7:0]        data_out;

    int n_checks = 0;
    int n_fail   = 0;
    int pend     = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    flux_byte_asm #(.CELL_W(CELL_W)) u_flux_byte_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .read_en    (read_en),
        .flux_pulse (flux_pulse),
        .cell_len   (cell_len),
        .data_rd    (mon_rd | man_rd),
        .data_out   (data_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // Monitor: pops the expected byte whenever a new one is waiting, then reads it
    always @(negedge clk) begin
        if (mon_rd) begin
            mon_rd <= 1'b0;
        end else if (mon_on && data_out[7]) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected byte", data_out, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(data_out == e, "R3/R4/R5 byte", data_out, e);
            end
            mon_rd <= 1'b1;
        end
    end

    // Pulse on the n-th clock edge from now (timed from a negedge)
    task automatic pulse_after(input int n);
        repeat (n - 1) @(negedge clk);
        flux_pulse = 1'b1;
        @(negedge clk);
        flux_pulse = 1'b0;
    endtask

    // Driver: encode a byte as pulse spacing; optional jitter and early glitch
    task automatic send_byte(input logic [7:0] b, input int jit, input bit glitch, input bit expect_it);
        int L;
        L = int'(cell_len);
        if (expect_it) exp_q.push_back(b);
        for (int i = 7; i >= 0; i--) begin
            pend++;
            if (b[i]) begin
                if (glitch && pend >= 1 && i != 7) begin
                    pulse_after(2);
                    pulse_after(pend * L + ((i % 2) ? jit : -jit) - 2);
                end else begin
                    pulse_after(pend * L + ((i % 2) ? jit : -jit));
                end
                pend = 0;
            end
        end
    endtask

    task automatic flush();
        repeat ((pend + 3) * int'(cell_len)) @(negedge clk);
        pend = 0;
    endtask

    task automatic start_read();
        @(negedge clk);
        read_en = 1'b1;
        pend = 0;
    endtask

    task automatic stop_read();
        @(negedge clk);
        read_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(data_out == 8'h00, "R1 reset data", data_out, 0);

        // R3 R4 R5: nominal cell length 8, several patterns and jitter
        mon_on = 1'b1;
        start_read();
        send_byte(8'hFF, 0, 1'b0, 1'b1);
        send_byte(8'h96, 1, 1'b0, 1'b1);
        send_byte(8'hD5, -1, 1'b0, 1'b1);
        send_byte(8'h81, 2, 1'b0, 1'b1);
        send_byte(8'hAA, -2, 1'b0, 1'b1);
        send_byte(8'h80, 0, 1'b0, 1'b1);
        send_byte(8'hB3, 3, 1'b0, 1'b1);
        flush();
        check(exp_q.size() == 0, "R5 all bytes framed (L=8)", exp_q.size(), 0);

        // R2: glitch pulses early in each cell are rejected
        send_byte(8'hEB, 0, 1'b1, 1'b1);
        send_byte(8'hCD, 1, 1'b1, 1'b1);
        flush();
        check(exp_q.size() == 0, "R2 glitches rejected", exp_q.size(), 0);

        // R7: partial byte discarded when read mode drops
        send_byte(8'h07, 0, 1'b0, 1'b0);   // leaves 1,1,1 in assembly register
        stop_read();
        repeat (5) pulse_after(3);
        check(data_out == 8'h00, "R7 idle pulses ignored", data_out, 0);
        start_read();
        send_byte(8'hC3, 0, 1'b0, 1'b1);
        flush();
        check(exp_q.size() == 0, "R7 partial byte cleared", exp_q.size(), 0);

        // R8: overwrite without read, R7 hold, R6 read clear
        mon_on = 1'b0;
        @(negedge clk);
        send_byte(8'h9C, 0, 1'b0, 1'b0);
        send_byte(8'hE1, 1, 1'b0, 1'b0);
        flush();
        check(data_out == 8'hE1, "R8 overwrite", data_out, 8'hE1);
        stop_read();
        repeat (4) pulse_after(5);
        check(data_out == 8'hE1, "R7 data held while idle", data_out, 8'hE1);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        check(data_out == 8'h00, "R6 read clears", data_out, 0);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        check(data_out == 8'h00, "R6 read of empty register", data_out, 0);

        // R9: odd cell length 7 (margin 3)
        cell_len = 6'd7;
        mon_on = 1'b1;
        start_read();
        send_byte(8'hA5, 1, 1'b0, 1'b1);
        send_byte(8'h88, -2, 1'b0, 1'b1);
        send_byte(8'hF0, 2, 1'b1, 1'b1);
        flush();
        check(exp_q.size() == 0, "R9 odd cell length", exp_q.size(), 0);
        stop_read();

        // R9: long cell length 14 (margin 7)
        cell_len = 6'd14;
        start_read();
        send_byte(8'hC9, 5, 1'b0, 1'b1);
        send_byte(8'h84, -5, 1'b1, 1'b1);
        flush();
        check(exp_q.size() == 0, "R9 long cell length", exp_q.size(), 0);
        stop_read();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule